// File: doc/BRIEF.md
# GPIO Port with Timer-Clock Override

This block is an eight-bit general-purpose I/O port. It has a port data register and a direction register, both on a simple register bus. Each pin is either a driven output or a plain input. The port data register is a set of latches. Reading it returns the latch value for output bits and the synchronized pin level for input bits. The direction register picks, bit by bit, whether the pin's output buffer is on.

Two pins can be taken over by the timers as external clock inputs. Bit 6 serves timer A and bit 4 serves timer B. A pin is taken over while its timer's external-clock select input is high. While it is taken over, its output buffer is held off whatever its direction bit says, and the pin level is passed out on that timer's clock output. The direction bit still picks what a read of that bit of the port data register returns.

Reset leaves every pin an input. The data latches have no reset and hold what was last written.

Top module: `gpio_tclk_port`

## Requirements
- R1: The port data register is at address 0x03 and the direction register is at address 0x07. A read of any other address returns 0x00.
- R2: After reset, every direction bit is 0, pin_oe is 0x00, and a read of address 0x07 returns 0x00.
- R3: For a pin that is not taken over, pin_oe[i] equals direction bit i, and pin_out[i] always shows data latch bit i.
- R4: A write to address 0x03 updates the data latches whatever the direction bits are. A value written while a pin is an input appears on pin_out, and is driven once the direction bit is set.
- R5: While tmra_ext_sel is 1, pin_oe[6] is 0 whatever direction bit 6 holds, and tmra_clk follows pin_in[6]. While tmra_ext_sel is 0, tmra_clk is 0 and bit 6 is an ordinary I/O bit.
- R6: While tmrb_ext_sel is 1, pin_oe[4] is 0 whatever direction bit 4 holds, and tmrb_clk follows pin_in[4]. While tmrb_ext_sel is 0, tmrb_clk is 0 and bit 4 is an ordinary I/O bit.
- R7: A read of address 0x03 returns, for each bit, the data latch where the direction bit is 1 and the synchronized pin level where it is 0. This also holds for pins taken over by a timer.
- R8: Pin levels reach the port read path through a two-flop synchronizer. A change at pin_in shows up in a read after the second rising clock edge, and not after the first.
- R9: A write to address 0x07 sets the direction register, and a read of 0x07 returns the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Value driven on each pin when its buffer is on |
| pin_oe | output | 8 | Output buffer enable for each pin |
| tmra_ext_sel | input | 1 | Timer A selects its external clock, which takes over pin 6 |
| tmrb_ext_sel | input | 1 | Timer B selects its external clock, which takes over pin 4 |
| tmra_clk | output | 1 | External clock passed to timer A |
| tmrb_clk | output | 1 | External clock passed to timer B |

## Verification
The bench drives direction masks of all ones, all zeros and mixed values, with the timer selects on and off. A design that let a set direction bit win over a timer claim would show a driven pin 6 or pin 4. A design that used the claim to choose the read source would return the pin level instead of the latch for a claimed output bit. Data writes made while a pin is an input are checked once the pin becomes an output, which catches latch writes gated by direction. The synchronizer is checked on both sides of its second edge, so a design with one flop or three flops shows a read that comes early or late.

// File: rtl/gpio_tclk_pkg.sv
package gpio_tclk_pkg;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned BUS_AW   = 8;
  localparam int unsigned DATA_ADR = 3;
  localparam int unsigned DIR_ADR  = 7;
  localparam int unsigned TMRA_BIT = 6;
  localparam int unsigned TMRB_BIT = 4;
  localparam int unsigned SYNC_N   = 2;
endpackage

// File: rtl/gpio_tclk_rst_sync.sv
module gpio_tclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[1];
endmodule

// File: rtl/gpio_tclk_in_sync.sv
module gpio_tclk_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = din;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

  // Checking aid: counts the edges since reset, so the latency check sees valid history only
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk
      assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_tclk_regs.sv
module gpio_tclk_regs #(
  parameter int unsigned W        = 8,
  parameter int unsigned AW       = 8,
  parameter int unsigned DATA_ADR = 3,
  parameter int unsigned DIR_ADR  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_sync,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  latch,
  output logic [W-1:0]  dir
);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_ADR);
  localparam logic [AW-1:0] A_DIR  = AW'(DIR_ADR);

  logic         data_en, dir_en;
  logic [W-1:0] data_q, data_d, dir_q, dir_d;

  always_comb begin
    data_en = we && (addr == A_DATA);
    dir_en  = we && (addr == A_DIR);
    data_d  = wdata;
    dir_d   = wdata;
  end

  // Data latches carry no reset
  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_comb begin
    if (addr == A_DATA)     rdata = (dir_q & data_q) | (~dir_q & pin_sync);
    else if (addr == A_DIR) rdata = dir_q;
    else                    rdata = '0;
  end

  assign latch = data_q;
  assign dir   = dir_q;

  assert_data_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |=> (latch == $past(wdata)));
  assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en |=> (dir == $past(wdata)));
endmodule

// File: rtl/gpio_tclk_pinmux.sv
module gpio_tclk_pinmux #(
  parameter int unsigned W    = 8,
  parameter int unsigned A_IX = 6,
  parameter int unsigned B_IX = 4
) (
  input  logic [W-1:0] dir,
  input  logic         sel_a,
  input  logic         sel_b,
  input  logic         pad_a,
  input  logic         pad_b,
  output logic [W-1:0] oe,
  output logic         clk_a,
  output logic         clk_b
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic claim;
      always_comb begin
        claim = ((i == A_IX) && sel_a) || ((i == B_IX) && sel_b);
        oe[i] = dir[i] && !claim;
      end
    end
  endgenerate

  assign clk_a = sel_a & pad_a;
  assign clk_b = sel_b & pad_b;
endmodule

// File: rtl/gpio_tclk_port.sv
module gpio_tclk_port
  import gpio_tclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  input  logic              tmra_ext_sel,
  input  logic              tmrb_ext_sel,
  output logic              tmra_clk,
  output logic              tmrb_clk
);
  logic              rst_int_n;
  logic [PORT_W-1:0] pin_sync, latch, dir;

  gpio_tclk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n));

  gpio_tclk_in_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(pin_in), .dout(pin_sync));

  gpio_tclk_regs #(.W(PORT_W), .AW(BUS_AW), .DATA_ADR(DATA_ADR), .DIR_ADR(DIR_ADR)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .pin_sync(pin_sync), .rdata(bus_rdata), .latch(latch), .dir(dir));

  gpio_tclk_pinmux #(.W(PORT_W), .A_IX(TMRA_BIT), .B_IX(TMRB_BIT)) u_mux (
    .dir(dir), .sel_a(tmra_ext_sel), .sel_b(tmrb_ext_sel),
    .pad_a(pin_in[TMRA_BIT]), .pad_b(pin_in[TMRB_BIT]),
    .oe(pin_oe), .clk_a(tmra_clk), .clk_b(tmrb_clk));

  assign pin_out = latch;

  assert_claim_a_off_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    tmra_ext_sel |-> !pin_oe[TMRA_BIT]);
  assert_claim_b_off_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    tmrb_ext_sel |-> !pin_oe[TMRB_BIT]);
  assert_read_latch_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == BUS_AW'(DATA_ADR)) |-> (((bus_rdata ^ pin_out) & dir) == '0));
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((bus_addr != BUS_AW'(DATA_ADR)) && (bus_addr != BUS_AW'(DIR_ADR))) |-> (bus_rdata == '0));
  assert_reset_dir_R2: assert property (@(posedge clk)
    $rose(rst_int_n) |-> (pin_oe == '0));
endmodule

// File: tb/tb_gpio_tclk_port.sv
module tb_gpio_tclk_port;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, bus_we, sel_a, sel_b, clk_a, clk_b;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  int errors = 0, checks = 0;

  gpio_tclk_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .tmra_ext_sel(sel_a),
    .tmrb_ext_sel(sel_b), .tmra_clk(clk_a), .tmrb_clk(clk_b));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {dir, data, pin, sel_a, sel_b, exp_oe, exp_rd, exp_clk_a, exp_clk_b}
  typedef struct packed {
    logic [7:0] dir; logic [7:0] data; logic [7:0] pin;
    logic sa; logic sb; logic [7:0] oe; logic [7:0] rd; logic ca; logic cb;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'hA5, 8'h00, 1'b0, 1'b0, 8'hFF, 8'hA5, 1'b0, 1'b0},
    '{8'h00, 8'h3C, 8'hC3, 1'b0, 1'b0, 8'h00, 8'hC3, 1'b0, 1'b0},
    '{8'hF0, 8'h5A, 8'h0F, 1'b0, 1'b0, 8'hF0, 8'h5F, 1'b0, 1'b0},
    '{8'hFF, 8'h00, 8'hFF, 1'b1, 1'b0, 8'hBF, 8'h00, 1'b1, 1'b0},
    '{8'hFF, 8'hFF, 8'h50, 1'b1, 1'b1, 8'hAF, 8'hFF, 1'b1, 1'b1},
    '{8'h00, 8'h00, 8'h10, 1'b0, 1'b1, 8'h00, 8'h10, 1'b0, 1'b1},
    '{8'h50, 8'h50, 8'h00, 1'b1, 1'b1, 8'h00, 8'h50, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a; #1; chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    pin_in = 8'h00; sel_a = 1'b0; sel_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: reset state
    chk("R2 oe after reset", pin_oe, 8'h00);
    rd_chk("R2 dir after reset", 8'h07, 8'h00);

    // R1: unmapped reads
    rd_chk("R1 addr 05", 8'h05, 8'h00);
    rd_chk("R1 addr FF", 8'hFF, 8'h00);

    // Vector walk: R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      bus_wr(8'h07, VECS[v].dir);
      bus_wr(8'h03, VECS[v].data);
      pin_in = VECS[v].pin; sel_a = VECS[v].sa; sel_b = VECS[v].sb;
      repeat (3) @(negedge clk);
      chk("R3 R5 R6 oe", pin_oe, VECS[v].oe);
      chk("R3 pin_out", pin_out, VECS[v].data);
      rd_chk("R7 data read", 8'h03, VECS[v].rd);
      chk("R5 tmra_clk", {7'd0, clk_a}, {7'd0, VECS[v].ca});
      chk("R6 tmrb_clk", {7'd0, clk_b}, {7'd0, VECS[v].cb});
    end

    // R5 and R6: clock follows the pin live; deselected gives 0 and normal oe
    sel_a = 1'b1; sel_b = 1'b1;
    pin_in = 8'h40; #1; chk("R5 clk follows pin", {7'd0, clk_a}, 8'h01);
    pin_in = 8'h10; #1; chk("R6 clk follows pin", {7'd0, clk_b}, 8'h01);
    chk("R5 clk low with pin", {7'd0, clk_a}, 8'h00);
    sel_a = 1'b0; sel_b = 1'b0; pin_in = 8'h50; #1;
    chk("R5 R6 deselected clk", {6'd0, clk_a, clk_b}, 8'h00);
    chk("R5 R6 deselected oe", pin_oe, 8'h50);

    // R9: direction readback
    bus_wr(8'h07, 8'h69);
    rd_chk("R9 dir readback", 8'h07, 8'h69);

    // R4: write while input, then make output
    bus_wr(8'h07, 8'h00);
    bus_wr(8'h03, 8'h99);
    chk("R4 latch with inputs", pin_out, 8'h99);
    chk("R4 not driven yet", pin_oe, 8'h00);
    bus_wr(8'h07, 8'hFF);
    chk("R4 driven after dir", pin_oe, 8'hFF);
    rd_chk("R4 read after dir", 8'h03, 8'h99);

    // R8: synchronizer latency
    bus_wr(8'h07, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    bus_addr = 8'h03;
    pin_in = 8'h77;
    @(negedge clk); #1; chk("R8 one edge", bus_rdata, 8'h00);
    @(negedge clk); #1; chk("R8 two edges", bus_rdata, 8'h77);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule